// File: doc/BRIEF.md
# Serial Port Interrupt Flag and Request Node

This block holds the receive and transmit status flags of a serial port and turns them into one interrupt request for the core. Hardware strobes from the receiver (stop bit captured) and from the transmitter set the flags. Software clears them through a write port that has one clear bit per flag. A request is latched only when a flag goes from 0 to 1, never on its level. The latched request waits in a pending bit until the node is free and both the node enable and the global interrupt enable are set. It is then presented to the core.

The node is tracked by a three-state machine. In `NODE_IDLE` no service is active. It moves to `NODE_REQ` ("raise") when the pending bit is set and both enables are 1. In `NODE_REQ` the request is shown to the core. From there it goes back to `NODE_IDLE` ("withdraw") if either enable drops, or on to `NODE_BUSY` ("enter") when the core acknowledges. Entry clears the pending bit. `NODE_BUSY` blocks the node, because it cannot interrupt itself. A return-from-interrupt moves it back to `NODE_IDLE` ("leave"), and any request latched in the meantime is presented one cycle later.

A hardware set takes precedence over a software clear in the same cycle. If software clears a flag just as a new frame sets it, the flag stays 1 and produces no edge. No new request is then latched, and the node stays silent until software really clears the flag and a later event sets it again. That lock-up is part of the required behaviour.

Top module: `sio_irq_node`

## Requirements
- R1: A 1 on `hw_set[i]` makes `flags[i]` equal to 1 after the next clock edge. Bit 0 is the receive flag and bit 1 is the transmit flag.
- R2: When `sw_wr` is 1, each flag whose `sw_wdata` bit is 0 is cleared after the edge. A `sw_wdata` bit of 1 leaves its flag unchanged.
- R3: When a set strobe and a software clear reach the same flag in the same cycle, the flag is 1 after the edge.
- R4: `pend` becomes 1 at the same edge at which any flag changes from 0 to 1. A set strobe on a flag that is already 1 does not set `pend`.
- R5: While the node is in service, a newly latched request keeps `pend` at 1 and `core_req` stays 0.
- R6: `core_req` is 1 one cycle after `pend` is 1 with the node idle and both `node_en` and `glob_en` at 1. It returns to 0 one cycle after either enable is 0.
- R7: `svc_ack` is accepted only while `core_req` is 1. An accepted acknowledge clears `pend` and enters service, unless a flag rises in the same cycle, in which case `pend` stays 1. An acknowledge at any other time changes nothing.
- R8: `reti` ends service. A request that is pending at that moment drives `core_req` to 1 one cycle later, provided both enables are 1.
- R9: After a set/clear collision on a flag that was already 1, no request is raised until software clears that flag and a later set strobe raises it again.
- R10: While `rst_n` is 0, the flags, `pend` and `core_req` are 0 and the node is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_set | input | NUM_FLAGS | Hardware set strobes (bit 0 receive, bit 1 transmit) |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | NUM_FLAGS | Write data: 0 clears the flag, 1 keeps it |
| node_en | input | 1 | Node interrupt enable |
| glob_en | input | 1 | Global interrupt enable |
| svc_ack | input | 1 | Core acknowledges entry into service |
| reti | input | 1 | Return-from-interrupt event |
| flags | output | NUM_FLAGS | Current flag values |
| pend | output | 1 | Pending request read-back |
| core_req | output | 1 | Request presented to the core |

## Verification
The bench builds the block with the default `NUM_FLAGS = 2`, which gives one receive and one transmit flag. With two flags, a collision can be placed on either flag while the other flag is used to show that a real edge still raises a request. This makes the lock-up observable on the transmit flag as well as on the receive flag. A single flag would also hide whether an edge on one flag during an acknowledge is merged correctly into the shared pending bit.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

    typedef enum logic [1:0] {
        NODE_IDLE = 2'd0,
        NODE_REQ  = 2'd1,
        NODE_BUSY = 2'd2
    } node_state_t;

    localparam int RX_BIT = 0;
    localparam int TX_BIT = 1;

endpackage

// File: rtl/sio_flag_cell.sv
module sio_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o,
    output logic rise_o
);

    logic flag_q;
    logic flag_d;

    // Hardware set dominates any software clear in the same cycle.
    always_comb begin
        flag_d = flag_q;
        if (clr_i) begin
            flag_d = 1'b0;
        end
        if (set_i) begin
            flag_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q;
    assign rise_o = flag_d & ~flag_q;

    // R1 / R3: a set strobe always leaves the flag at 1.
    p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    // R2: a clear without a set empties the flag.
    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);

    // R4: an edge is reported only when the flag is currently 0.
    p_rise_from_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> !flag_o);

endmodule

// File: rtl/sio_pend_latch.sv
module sio_pend_latch #(
    parameter int NUM_FLAGS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] rise_i,
    input  logic                 take_i,
    output logic                 pend_o
);

    logic pend_q;
    logic any_rise;

    assign any_rise = |rise_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (any_rise) begin
            pend_q <= 1'b1;
        end else if (take_i) begin
            pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    // R4 / R7: an edge always leaves a pending request, even against an acknowledge.
    p_edge_latches_r4: assert property (@(posedge clk) disable iff (!rst_n)
        any_rise |=> pend_o);

    // R5: without an edge or an acknowledge the pending bit holds.
    p_pend_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_rise && !take_i) |=> $stable(pend_o));

endmodule

// File: rtl/sio_node_fsm.sv
module sio_node_fsm
    import sio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    input  logic node_en_i,
    input  logic glob_en_i,
    input  logic svc_ack_i,
    input  logic reti_i,
    output logic core_req_o,
    output logic take_o
);

    node_state_t state_q;
    node_state_t state_d;
    logic        enabled;

    assign enabled = node_en_i & glob_en_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= NODE_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NODE_IDLE: begin
                if (pend_i && enabled) begin
                    state_d = NODE_REQ;
                end
            end
            NODE_REQ: begin
                if (svc_ack_i) begin
                    state_d = NODE_BUSY;
                end else if (!enabled || !pend_i) begin
                    state_d = NODE_IDLE;
                end
            end
            NODE_BUSY: begin
                if (reti_i) begin
                    state_d = NODE_IDLE;
                end
            end
            default: begin
                state_d = NODE_IDLE;
            end
        endcase
    end

    always_comb begin
        core_req_o = 1'b0;
        take_o     = 1'b0;
        unique case (state_q)
            NODE_IDLE: begin
                core_req_o = 1'b0;
            end
            NODE_REQ: begin
                core_req_o = 1'b1;
                take_o     = svc_ack_i;
            end
            NODE_BUSY: begin
                core_req_o = 1'b0;
            end
            default: begin
                core_req_o = 1'b0;
            end
        endcase
    end

    // R6: a request is shown only after pending and both enables were seen.
    p_req_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_req_o) |-> $past(pend_i && enabled));

    // R7: an acknowledge of a shown request enters service.
    p_ack_enters_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req_o && svc_ack_i) |=> (state_q == NODE_BUSY));

    // R8: return from interrupt frees the node.
    p_reti_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == NODE_BUSY && reti_i) |=> (state_q == NODE_IDLE));

    // R5: the node stays blocked until return from interrupt.
    p_busy_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == NODE_BUSY && !reti_i) |=> (state_q == NODE_BUSY));

endmodule

// File: rtl/sio_irq_node.sv
module sio_irq_node #(
    parameter int NUM_FLAGS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] hw_set,
    input  logic                 sw_wr,
    input  logic [NUM_FLAGS-1:0] sw_wdata,
    input  logic                 node_en,
    input  logic                 glob_en,
    input  logic                 svc_ack,
    input  logic                 reti,
    output logic [NUM_FLAGS-1:0] flags,
    output logic                 pend,
    output logic                 core_req
);

    logic [NUM_FLAGS-1:0] clr_vec;
    logic [NUM_FLAGS-1:0] rise_vec;
    logic                 take;

    assign clr_vec = {NUM_FLAGS{sw_wr}} & ~sw_wdata;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        sio_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (hw_set[g]),
            .clr_i  (clr_vec[g]),
            .flag_o (flags[g]),
            .rise_o (rise_vec[g])
        );
    end

    sio_pend_latch #(
        .NUM_FLAGS (NUM_FLAGS)
    ) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise_i (rise_vec),
        .take_i (take),
        .pend_o (pend)
    );

    sio_node_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_i     (pend),
        .node_en_i  (node_en),
        .glob_en_i  (glob_en),
        .svc_ack_i  (svc_ack),
        .reti_i     (reti),
        .core_req_o (core_req),
        .take_o     (take)
    );

    // R2: writing 1 to every clear bit without a set leaves the flags alone.
    p_write_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && (&sw_wdata) && hw_set == '0) |=> $stable(flags));

    // R7: an acknowledge while no request is shown leaves pending untouched.
    p_stray_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_ack && !core_req && hw_set == '0) |=> $stable(pend));

endmodule

// File: tb/sio_irq_node_test.sv
`timescale 1ns/1ps
module sio_irq_node_test;

    localparam int NF = 2;
    localparam int NV = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NF-1:0] hw_set;
    logic          sw_wr;
    logic [NF-1:0] sw_wdata;
    logic          node_en;
    logic          glob_en;
    logic          svc_ack;
    logic          reti;
    logic [NF-1:0] flags;
    logic          pend;
    logic          core_req;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sio_irq_node #(.NUM_FLAGS(NF)) uut (
        .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .sw_wr(sw_wr),
        .sw_wdata(sw_wdata), .node_en(node_en), .glob_en(glob_en),
        .svc_ack(svc_ack), .reti(reti), .flags(flags), .pend(pend),
        .core_req(core_req)
    );

    // hw[12:11] wr[10] wd[9:8] ne[7] ge[6] ack[5] reti[4] | flags[3:2] pend[1] req[0]
    localparam logic [12:0] VEC [NV] = '{
        13'b01_0_00_1_1_0_0_01_1_0,
        13'b00_0_00_1_1_0_0_01_1_1,
        13'b00_0_00_1_1_1_0_01_0_0,
        13'b01_0_00_1_1_0_0_01_0_0,
        13'b00_1_10_1_1_0_0_00_0_0,
        13'b01_0_00_1_1_0_0_01_1_0,
        13'b00_0_00_1_1_0_0_01_1_0,
        13'b00_0_00_1_1_0_1_01_1_0,
        13'b00_0_00_1_1_0_0_01_1_1,
        13'b00_0_00_1_1_1_0_01_0_0,
        13'b01_1_10_1_1_0_0_01_0_0,
        13'b00_0_00_1_1_0_1_01_0_0,
        13'b00_0_00_1_1_0_0_01_0_0,
        13'b00_1_11_1_1_0_0_01_0_0,
        13'b00_1_10_1_1_0_0_00_0_0,
        13'b10_0_00_1_1_0_0_10_1_0,
        13'b00_0_00_0_1_0_0_10_1_0,
        13'b00_0_00_1_0_0_0_10_1_0,
        13'b00_0_00_1_1_0_0_10_1_1,
        13'b00_0_00_1_0_0_0_10_1_0,
        13'b00_0_00_1_1_0_0_10_1_1,
        13'b01_0_00_1_1_1_0_11_1_0,
        13'b00_0_00_1_1_0_1_11_1_0,
        13'b00_0_00_1_1_0_0_11_1_1,
        13'b00_0_00_1_1_1_0_11_0_0,
        13'b00_1_00_1_1_0_0_00_0_0,
        13'b00_0_00_1_1_0_1_00_0_0,
        13'b01_0_00_1_1_0_0_01_1_0,
        13'b00_0_00_0_1_1_0_01_1_0,
        13'b00_0_00_1_1_0_0_01_1_1,
        13'b00_0_00_1_1_1_0_01_0_0,
        13'b00_0_00_1_1_0_1_01_0_0
    };

    localparam string TAG [NV] = '{
        "R4", "R6", "R7", "R4", "R2", "R5", "R5", "R8",
        "R8", "R7", "R3", "R8", "R9", "R2", "R9", "R1",
        "R6", "R6", "R6", "R6", "R6", "R7", "R5", "R8",
        "R7", "R2", "R8", "R1", "R7", "R6", "R7", "R8"
    };

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s flags/pend/req actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step(input logic [NF-1:0] h, input logic w, input logic [NF-1:0] d,
                        input logic ne, input logic ge, input logic a, input logic r);
        hw_set = h; sw_wr = w; sw_wdata = d;
        node_en = ne; glob_en = ge; svc_ack = a; reti = r;
        @(posedge clk);
        @(negedge clk);
        hw_set = '0; sw_wr = 1'b0; sw_wdata = '1; svc_ack = 1'b0; reti = 1'b0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; hw_set = '0; sw_wr = 1'b0; sw_wdata = '1;
        node_en = 1'b0; glob_en = 1'b0; svc_ack = 1'b0; reti = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset", {flags, pend, core_req}, 4'b0000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][12:11], VEC[i][10], VEC[i][9:8], VEC[i][7], VEC[i][6],
                 VEC[i][5], VEC[i][4]);
            check(TAG[i], {flags, pend, core_req}, VEC[i][3:0]);
        end

        // Collision on the transmit flag (R3, R9)
        step(2'b10, 1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R1 tx set", {flags, pend, core_req}, 4'b1110);
        step(2'b00, 1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R6 tx req", {flags, pend, core_req}, 4'b1111);
        step(2'b00, 1'b0, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0);
        check("R7 tx ack", {flags, pend, core_req}, 4'b1100);
        step(2'b10, 1'b1, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R3 tx collision", {flags, pend, core_req}, 4'b1100);
        step(2'b00, 1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1);
        step(2'b00, 1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R9 tx silent", {flags, pend, core_req}, 4'b1100);
        step(2'b00, 1'b1, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R2 tx clear", {flags, pend, core_req}, 4'b0100);
        step(2'b10, 1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0);
        step(2'b00, 1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R9 tx recovered", {flags, pend, core_req}, 4'b1111);

        // Reset in mid-run
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R10 mid-run reset", {flags, pend, core_req}, 4'b0000);
        rst_n = 1'b1;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule